// File: doc/BRIEF.md
# Whole-Line Write Coverage Tracker

This block sits beside one miss-buffer entry of a cache and tracks which bytes of the entry's line have been written by the requests merged into it. It helps the cache decide whether an outgoing miss can be sent as a full-line write that needs no fill data. Each accepted request gives a write flag, a byte-enable (masked) flag, a flag for special attributes (uncacheable, strictly ordered, privileged, load-locked/store-conditional, swap, conditional swap, secure or locked read-modify-write), a byte offset inside the line and a size in bytes. The block keeps one coverage bit per byte and a merge-allowed flag. It raises a full-line output once every byte is covered.

An allocation strobe starts a new entry. It clears the coverage, allows merging again and marks the next request as the entry's first. The block carries no write data. It does not decide whether a request belongs to the entry; it only records coverage for requests it is told were accepted. All outputs are registered and change on the clock edge that follows the request.

Top module: `wlc_top`

## Requirements
- R1: After reset or an allocation without a request, the coverage map is all zero, merging is allowed, the full-line output is low, and the next request counts as the entry's first.
- R2: A non-masked write that is merge-compatible sets coverage bits offset through offset+size-1 while merging is allowed. Merging stays allowed after it.
- R3: The first request of an entry, if it is a non-masked write with special attributes, still sets its coverage bits. Merging is disabled from the next cycle.
- R4: A non-write request that arrives while merging is allowed sets no bits and disables merging until the next allocation.
- R5: A masked write never sets coverage bits. Merging stays allowed after it only if it was merge-compatible.
- R6: While merging is disabled, no request changes the coverage map.
- R7: Once the line is fully covered, no request (read, special or plain write) changes the coverage map or the merge flag until the next allocation.
- R8: The full-line output is high in the cycle after the request that sets the last uncovered bit, and low whenever any bit is clear.
- R9: A request whose offset plus size exceeds the line size (64 bytes by default) pulses the range-error output for exactly the following cycle and sets no bits. It still counts as the entry's first request.
- R10: When an allocation and a request arrive in the same cycle, the request is applied to the fresh entry as its first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocStrb | input | 1 | Start a new entry |
| reqValid | input | 1 | An accepted request is presented |
| reqIsWrite | input | 1 | Request is a write |
| reqMasked | input | 1 | Write uses byte enables |
| reqSpecial | input | 1 | Request carries an attribute that forbids merging |
| reqOffset | input | OFF_W (6) | Byte offset in the line |
| reqSize | input | SZ_W (7) | Size in bytes |
| coverMap | output | LINE_BYTES (64) | One bit per covered byte |
| lineFull | output | 1 | Every byte is covered |
| mergeOk | output | 1 | Further writes may still merge |
| rangeErr | output | 1 | Previous request overran the line |

## Verification
Allocation and request handling can fall in the same cycle. In that case the clear must win over the old state, and the request must then act as the first of the new entry. The bench provokes this while the previous entry is fully covered. It also does so with a special-attribute write, which must still set its bits. It judges the result from the map, full and merge outputs one edge later against a reference model. The model applies the clear first and then the request.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  typedef struct packed {
    logic clearMap;    // drop all coverage
    logic setRange;    // OR the request range into the map
    logic checkRange;  // a request is present: test its range
  } covStrb_t;
endpackage

// File: rtl/wlc_ctrl.sv
module wlc_ctrl
  import wlc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     allocStrb,
  input  logic     reqValid,
  input  logic     reqIsWrite,
  input  logic     reqMasked,
  input  logic     reqSpecial,
  input  logic     lineFull,
  output covStrb_t strb,
  output logic     mergeOk
);
  logic firstReq;
  logic effFull, effMerge, effFirst;
  logic nextMerge, nextFirst;

  // allocation acts before the request of the same cycle
  assign effFull  = lineFull && !allocStrb;
  assign effMerge = allocStrb || mergeOk;
  assign effFirst = allocStrb || firstReq;

  always_comb begin
    strb.clearMap   = allocStrb;
    strb.checkRange = reqValid;
    strb.setRange   = reqValid && !effFull && effMerge && reqIsWrite &&
                      !reqMasked && (effFirst || !reqSpecial);
    nextMerge = effMerge;
    if (reqValid && !effFull && effMerge)
      nextMerge = reqIsWrite && !reqSpecial;
    nextFirst = reqValid ? 1'b0 : effFirst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mergeOk  <= 1'b1;
      firstReq <= 1'b1;
    end else begin
      mergeOk  <= nextMerge;
      firstReq <= nextFirst;
    end
  end

  // R4: once merging is off it stays off until allocation
  a_r4_merge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!mergeOk && !allocStrb) |=> !mergeOk);

  // R3: a special write on a live, not-full entry ends merging
  a_r3_special_ends_merge: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsWrite && reqSpecial && (allocStrb || !lineFull)) |=> !mergeOk);
endmodule

// File: rtl/wlc_cover.sv
module wlc_cover
  import wlc_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int SZ_W       = $clog2(LINE_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  covStrb_t              strb,
  input  logic [OFF_W-1:0]      reqOffset,
  input  logic [SZ_W-1:0]       reqSize,
  output logic [LINE_BYTES-1:0] coverMap,
  output logic                  lineFull,
  output logic                  rangeErr
);
  localparam int SUM_W = SZ_W + 1;

  logic [SUM_W-1:0]      startPos, endPos;
  logic                  overflow;
  logic [LINE_BYTES-1:0] rangeMask;
  logic [LINE_BYTES-1:0] nextMap;

  assign startPos = SUM_W'(reqOffset);
  assign endPos   = startPos + SUM_W'(reqSize);
  assign overflow = endPos > SUM_W'(LINE_BYTES);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign rangeMask[b] = (SUM_W'(b) >= startPos) && (SUM_W'(b) < endPos);
  end

  always_comb begin
    nextMap = strb.clearMap ? '0 : coverMap;
    if (strb.setRange && !overflow)
      nextMap = nextMap | rangeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coverMap <= '0;
      rangeErr <= 1'b0;
    end else begin
      coverMap <= nextMap;
      rangeErr <= strb.checkRange && overflow;
    end
  end

  assign lineFull = &coverMap;

  // R7: full coverage survives every request until a clear
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lineFull && !strb.clearMap) |=> lineFull);

  // R9: an overrunning request leaves the map untouched
  a_r9_overrun_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (strb.checkRange && overflow && !strb.clearMap) |=> $stable(coverMap));

  // R2: without a clear, coverage only grows
  a_r2_monotone: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearMap |=> ((coverMap & $past(coverMap)) == $past(coverMap)));
endmodule

// File: rtl/wlc_top.sv
module wlc_top
  import wlc_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SZ_W      = $clog2(LINE_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  allocStrb,
  input  logic                  reqValid,
  input  logic                  reqIsWrite,
  input  logic                  reqMasked,
  input  logic                  reqSpecial,
  input  logic [OFF_W-1:0]      reqOffset,
  input  logic [SZ_W-1:0]       reqSize,
  output logic [LINE_BYTES-1:0] coverMap,
  output logic                  lineFull,
  output logic                  mergeOk,
  output logic                  rangeErr
);
  covStrb_t strb;

  wlc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocStrb  (allocStrb),
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .reqMasked  (reqMasked),
    .reqSpecial (reqSpecial),
    .lineFull   (lineFull),
    .strb       (strb),
    .mergeOk    (mergeOk)
  );

  wlc_cover #(
    .LINE_BYTES (LINE_BYTES),
    .OFF_W      (OFF_W),
    .SZ_W       (SZ_W)
  ) u_cover (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOffset (reqOffset),
    .reqSize   (reqSize),
    .coverMap  (coverMap),
    .lineFull  (lineFull),
    .rangeErr  (rangeErr)
  );

  // R5: a masked write on a live entry never adds coverage
  a_r5_masked_no_bits: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsWrite && reqMasked && !allocStrb) |=> $stable(coverMap));

  // R1: a bare allocation yields an empty, mergeable entry
  a_r1_alloc_clears: assert property (@(posedge clk) disable iff (!rstN)
    (allocStrb && !reqValid) |=> (coverMap == '0 && mergeOk && !lineFull));
endmodule

// File: tb/wlc_top_bench.sv
module wlc_top_bench;
  localparam int LB = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic        allocStrb, reqValid, reqIsWrite, reqMasked, reqSpecial;
  logic [5:0]  reqOffset;
  logic [6:0]  reqSize;
  logic [63:0] coverMap;
  logic        lineFull, mergeOk, rangeErr;

  always #2 clk = ~clk;  // 250 MHz

  wlc_top u_wlc_top (
    .clk(clk), .rstN(rstN), .allocStrb(allocStrb), .reqValid(reqValid),
    .reqIsWrite(reqIsWrite), .reqMasked(reqMasked), .reqSpecial(reqSpecial),
    .reqOffset(reqOffset), .reqSize(reqSize), .coverMap(coverMap),
    .lineFull(lineFull), .mergeOk(mergeOk), .rangeErr(rangeErr)
  );

  typedef struct {
    logic [63:0] map;
    logic        full;
    logic        merge;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;
  logic [63:0] mMap;
  logic        mMerge, mFirst;

  // driver: present one cycle of stimulus and push the model's prediction
  task automatic step(input bit al, input bit v, input bit wr, input bit mk,
                      input bit sp, input int off, input int sz, input string tag);
    expItem_t e;
    bit ovf;
    @(negedge clk);
    allocStrb = al; reqValid = v; reqIsWrite = wr; reqMasked = mk;
    reqSpecial = sp; reqOffset = 6'(off); reqSize = 7'(sz);
    ovf = (off + sz) > LB;
    if (al) begin mMap = '0; mMerge = 1'b1; mFirst = 1'b1; end
    if (v) begin
      if (!(&mMap) && mMerge) begin
        if (!wr) mMerge = 1'b0;
        else begin
          if (!mk && (mFirst || !sp) && !ovf)
            for (int b = off; b < off + sz; b++) mMap[b] = 1'b1;
          mMerge = !sp;
        end
      end
      mFirst = 1'b0;
    end
    e.map = mMap; e.full = &mMap; e.merge = mMerge; e.err = v && ovf; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare after the edge that follows each request
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (coverMap !== e.map || lineFull !== e.full ||
            mergeOk !== e.merge || rangeErr !== e.err) begin
          failures++;
          $display("FAIL %s: map=%h full=%b merge=%b err=%b expected map=%h full=%b merge=%b err=%b",
                   e.tag, coverMap, lineFull, mergeOk, rangeErr,
                   e.map, e.full, e.merge, e.err);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; allocStrb = 0; reqValid = 0; reqIsWrite = 0; reqMasked = 0;
    reqSpecial = 0; reqOffset = '0; reqSize = '0;
    mMap = '0; mMerge = 1'b1; mFirst = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0,0,0,0,0, 0,0, "R1 reset state");
    // R2 plain merging writes
    step(0,1,1,0,0, 0,16, "R2 first plain write");
    step(0,1,1,0,0, 20,8, "R2 second plain write");
    // R3 special first write still counts, then R6 blocks the rest
    step(1,0,0,0,0, 0,0, "R1 allocation clears");
    step(0,1,1,0,1, 0,8, "R3 special first write");
    step(0,1,1,0,0, 8,8, "R6 write after merge off");
    // R4 read stops merging
    step(1,1,1,0,0, 0,32, "R10 alloc with write");
    step(0,1,0,0,0, 0,4, "R4 read disables merging");
    step(0,1,1,0,0, 32,32, "R6 write ignored after read");
    // R5 masked write
    step(1,0,0,0,0, 0,0, "R1 allocation clears");
    step(0,1,1,1,0, 0,64, "R5 masked write no bits");
    step(0,1,1,0,0, 0,32, "R2 lower half");
    step(0,1,1,1,1, 32,32, "R5 masked special write");
    step(1,1,1,0,0, 0,32, "R10 alloc with lower half");
    step(0,1,1,0,0, 32,32, "R8 completes line");
    step(0,1,0,0,0, 0,8, "R7 read on full line");
    step(0,1,1,0,1, 0,8, "R7 special write on full line");
    // R10 allocation with a special write while full
    step(1,1,1,0,1, 4,4, "R10 alloc plus special write");
    // R9 overrun
    step(1,0,0,0,0, 0,0, "R1 allocation clears");
    step(0,1,1,0,0, 60,8, "R9 overrun write");
    step(0,1,1,0,0, 0,4, "R9 error pulse ends");
    step(0,1,1,0,0, 4,60, "R8 exact end of line");
    step(0,0,0,0,0, 0,0, "R8 full held idle");
    step(0,0,0,0,0, 0,0, "drain");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule